// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block decides whether a CAN controller is asleep, being configured, or taking part in bus traffic. Software holds four control bits in the block: a sleep request, an initialization request, an automatic wake-up enable and a wake-up interrupt enable. The block answers with two acknowledge flags, a mode code and a clock enable for the protocol core. The clock enable is low whenever the controller sleeps.

Leaving sleep, or leaving initialization, is a two-step handshake. First the request bit is cleared. Then the block waits until it has seen a run of recessive bits on the receive line, sampled at a bit-rate strobe, before it drops the acknowledge. While asleep, a dominant edge on the synchronized receive line counts as bus activity. Bus activity can clear the sleep request in hardware and can raise a wake-up interrupt pulse.

Top module: `can_mode_seq`

## Requirements
- R1: When the sleep request bit is set in normal or initialization mode, the block is in sleep mode one clock later. In sleep mode, sleep_ack_o is 1, mode_o is 2 and core_clk_en_o is 0.
- R2: The four control bits can be written through cfg_we and read back on their output ports in every mode, sleep included.
- R3: An initialization request made while in sleep mode is not acknowledged: init_ack_o stays 0 for as long as the block remains asleep.
- R4: When software clears the sleep request, sleep mode is left after bus synchronization. The block goes to normal mode (mode_o 0) if the initialization request is clear, or to initialization mode (mode_o 1, init_ack_o 1) if it is set.
- R5: Bus activity in sleep mode clears the sleep request bit in hardware only when the automatic wake-up enable is 1. Otherwise the bit stays set until software clears it.
- R6: On bus activity in sleep mode, wake_irq_o pulses high for one clock whenever the interrupt enable is 1, whether or not hardware also clears the sleep request. It stays 0 when the enable is 0.
- R7: Synchronization needs SYNC_BITS (default 11) consecutive recessive samples (rx_i = 1) taken on cycles where bit_tick_i is 1. A dominant sample restarts the count. sleep_ack_o stays 1 until the last of those samples.
- R8: After reset the block is in sleep mode with the sleep request bit at 1, the other three control bits at 0, sleep_ack_o at 1, init_ack_o at 0 and core_clk_en_o at 0.
- R9: In normal mode, setting the initialization request enters initialization mode one clock later. Clearing it returns the block to normal mode only after synchronization.
- R10: rx_i passes through a two-stage synchronizer. Bus activity is a 1-to-0 transition of the synchronized value while in sleep mode, so wake-up effects appear on the third rising clock edge after rx_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the four control bits |
| cfg_sleep | input | 1 | Sleep request value to write |
| cfg_init | input | 1 | Initialization request value to write |
| cfg_awake | input | 1 | Automatic wake-up enable value to write |
| cfg_wkie | input | 1 | Wake-up interrupt enable value to write |
| rx_i | input | 1 | Raw CAN receive line, 1 = recessive |
| bit_tick_i | input | 1 | Bit-rate sample strobe |
| sleep_rq_o | output | 1 | Sleep request bit readback |
| init_rq_o | output | 1 | Initialization request bit readback |
| awake_en_o | output | 1 | Automatic wake-up enable readback |
| wkie_en_o | output | 1 | Wake-up interrupt enable readback |
| sleep_ack_o | output | 1 | Sleep acknowledge |
| init_ack_o | output | 1 | Initialization acknowledge |
| core_clk_en_o | output | 1 | Protocol core clock enable |
| mode_o | output | 2 | Mode code: 0 normal, 1 initialization, 2 sleep |
| wake_irq_o | output | 1 | One-clock wake-up interrupt pulse |

## Verification
A wrong state code shows at once on mode_o, on the acknowledge flags and on the clock enable. The bench compares all of them one clock after each request edge. A recessive counter that is wrong by one shows only at the end of a synchronization window: the acknowledge falls one strobe early or one strobe late. The table of dominant-bit positions therefore checks both sides of that boundary. A fault in the synchronizer or the edge detector moves the interrupt pulse and the hardware clear off the third clock edge, and the activity tests sample exactly there.

// File: rtl/can_mode_seq.sv
module can_mode_seq #(
  parameter int SYNC_BITS = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_sleep,
  input  logic       cfg_init,
  input  logic       cfg_awake,
  input  logic       cfg_wkie,
  input  logic       rx_i,
  input  logic       bit_tick_i,
  output logic       sleep_rq_o,
  output logic       init_rq_o,
  output logic       awake_en_o,
  output logic       wkie_en_o,
  output logic       sleep_ack_o,
  output logic       init_ack_o,
  output logic       core_clk_en_o,
  output logic [1:0] mode_o,
  output logic       wake_irq_o
);
  localparam int CW = $clog2(SYNC_BITS + 1);

  typedef enum logic [1:0] {
    M_NORMAL = 2'd0,
    M_INIT   = 2'd1,
    M_SLEEP  = 2'd2
  } mode_t;

  mode_t mode_q, mode_d;
  logic sleep_rq, init_rq, awake_en, wkie;
  logic rx_m, rx_s, rx_d;
  logic [CW-1:0] rec_cnt;
  logic leaving, sync_done, bus_act, wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_d <= 1'b1;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
      rx_d <= rx_s;
    end
  end

  assign bus_act   = (mode_q == M_SLEEP) && rx_d && !rx_s;
  assign leaving   = ((mode_q == M_SLEEP) && !sleep_rq) ||
                     ((mode_q == M_INIT) && !init_rq && !sleep_rq);
  assign sync_done = leaving && bit_tick_i && rx_s &&
                     (rec_cnt == CW'(SYNC_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rec_cnt <= '0;
    else if (!leaving || sync_done)
      rec_cnt <= '0;
    else if (bit_tick_i)
      rec_cnt <= rx_s ? rec_cnt + 1'b1 : '0;
  end

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      M_SLEEP:  if (sync_done) mode_d = init_rq ? M_INIT : M_NORMAL;
      M_INIT:   if (sleep_rq) mode_d = M_SLEEP;
                else if (sync_done) mode_d = M_NORMAL;
      default:  if (sleep_rq) mode_d = M_SLEEP;
                else if (init_rq) mode_d = M_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_SLEEP;
      sleep_rq <= 1'b1;
      init_rq  <= 1'b0;
      awake_en <= 1'b0;
      wkie     <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      wake_q <= bus_act && wkie;
      if (cfg_we) begin
        sleep_rq <= cfg_sleep;
        init_rq  <= cfg_init;
        awake_en <= cfg_awake;
        wkie     <= cfg_wkie;
      end else if (bus_act && awake_en) begin
        sleep_rq <= 1'b0;
      end
    end
  end

  assign sleep_rq_o    = sleep_rq;
  assign init_rq_o     = init_rq;
  assign awake_en_o    = awake_en;
  assign wkie_en_o     = wkie;
  assign sleep_ack_o   = (mode_q == M_SLEEP);
  assign init_ack_o    = (mode_q == M_INIT);
  assign core_clk_en_o = (mode_q != M_SLEEP);
  assign mode_o        = mode_q;
  assign wake_irq_o    = wake_q;
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       bit_tick_i,
  input logic       sleep_rq_o,
  input logic       awake_en_o,
  input logic       wkie_en_o,
  input logic       sleep_ack_o,
  input logic       init_ack_o,
  input logic       core_clk_en_o,
  input logic [1:0] mode_o,
  input logic       wake_irq_o
);
  // R1
  sleep_gates_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack_o |-> !core_clk_en_o);

  // R1
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_rq_o && !cfg_we && mode_o != 2'd2) |=> sleep_ack_o);

  // R3
  no_dual_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_ack_o |-> !sleep_ack_o);

  // R5
  manual_wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_rq_o && !awake_en_o && !cfg_we) |=> sleep_rq_o);

  // R6
  irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq_o |-> $past(wkie_en_o));

  // R7
  exit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_ack_o) |-> $past(bit_tick_i));
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .bit_tick_i(bit_tick_i),
  .sleep_rq_o(sleep_rq_o), .awake_en_o(awake_en_o), .wkie_en_o(wkie_en_o),
  .sleep_ack_o(sleep_ack_o), .init_ack_o(init_ack_o),
  .core_clk_en_o(core_clk_en_o), .mode_o(mode_o), .wake_irq_o(wake_irq_o)
);

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sleep = 1'b0, cfg_init = 1'b0, cfg_awake = 1'b0, cfg_wkie = 1'b0;
  logic rx_i = 1'b1, bit_tick_i = 1'b0;
  logic sleep_rq_o, init_rq_o, awake_en_o, wkie_en_o;
  logic sleep_ack_o, init_ack_o, core_clk_en_o, wake_irq_o;
  logic [1:0] mode_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  can_mode_seq dut (.*);

  localparam int ROWS = 8;
  localparam int POS [ROWS] = '{99, 99, 0, 0, 5, 5, 10, 10};
  localparam int NT  [ROWS] = '{10, 11, 11, 12, 16, 17, 21, 22};
  localparam bit EXP [ROWS] = '{1, 0, 1, 0, 1, 0, 1, 0};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 1'b0; rx_i = 1'b1; bit_tick_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic i, input logic a, input logic w);
    @(negedge clk);
    cfg_sleep = s; cfg_init = i; cfg_awake = a; cfg_wkie = w; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tick(input logic rxv);
    @(negedge clk);
    rx_i = rxv;
    repeat (3) @(negedge clk);
    bit_tick_i = 1'b1;
    @(negedge clk);
    bit_tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick(1'b1);
  endtask

  task automatic activity(output int irq_at3, output int irq_at4);
    @(negedge clk);
    rx_i = 1'b0;
    repeat (3) @(negedge clk);
    irq_at3 = wake_irq_o;
    @(negedge clk);
    irq_at4 = wake_irq_o;
    rx_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int i3, i4;
    do_reset();
    // R8 reset state
    chk("R8 sleep_ack", sleep_ack_o, 1);
    chk("R8 init_ack", init_ack_o, 0);
    chk("R8 clk_en", core_clk_en_o, 0);
    chk("R8 mode", mode_o, 2);
    chk("R8 sleep_rq", sleep_rq_o, 1);
    chk("R8 other bits", {init_rq_o, awake_en_o, wkie_en_o}, 0);

    // R7 synchronization window table
    for (int r = 0; r < ROWS; r++) begin
      do_reset();
      wr(1'b0, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < NT[r]; k++) tick(k == POS[r] ? 1'b0 : 1'b1);
      chk($sformatf("R7 row%0d sleep_ack", r), sleep_ack_o, EXP[r]);
    end

    // R2 writes visible in sleep; R3 init not acked in sleep
    do_reset();
    wr(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R2 readback", {sleep_rq_o, init_rq_o, awake_en_o, wkie_en_o}, 15);
    ticks(12);
    chk("R3 init_ack in sleep", init_ack_o, 0);
    chk("R3 still sleep", mode_o, 2);
    wr(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2 readback2", {sleep_rq_o, init_rq_o, awake_en_o, wkie_en_o}, 12);

    // R4 leave sleep to init
    wr(1'b0, 1'b1, 1'b0, 1'b0);
    ticks(10);
    chk("R4 before sync", sleep_ack_o, 1);
    ticks(1);
    chk("R4 into init mode", mode_o, 1);
    chk("R4 init_ack", init_ack_o, 1);
    chk("R4 clk_en", core_clk_en_o, 1);

    // R9 init to normal after sync
    wr(1'b0, 1'b0, 1'b0, 1'b0);
    ticks(10);
    chk("R9 init held", init_ack_o, 1);
    ticks(1);
    chk("R9 normal", mode_o, 0);
    // R9 normal to init in one clock
    @(negedge clk);
    cfg_sleep = 1'b0; cfg_init = 1'b1; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R9 init entry", init_ack_o, 1);
    wr(1'b0, 1'b0, 1'b0, 1'b0);
    ticks(11);
    chk("R9 back normal", mode_o, 0);

    // R1 normal to sleep in one clock
    @(negedge clk);
    cfg_sleep = 1'b1; cfg_init = 1'b0; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R1 not yet", mode_o, 0);
    @(negedge clk);
    chk("R1 sleep mode", mode_o, 2);
    chk("R1 clk gated", core_clk_en_o, 0);

    // R5 R6 R10 auto wake with interrupt
    wr(1'b1, 1'b0, 1'b1, 1'b1);
    activity(i3, i4);
    chk("R10 irq on third edge", i3, 1);
    chk("R6 irq single pulse", i4, 0);
    chk("R5 hw cleared sleep_rq", sleep_rq_o, 0);
    chk("R7 ack held after wake", sleep_ack_o, 1);
    ticks(11);
    chk("R4 auto wake normal", mode_o, 0);

    // R5 R6 manual wake: irq but bit kept
    wr(1'b1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    activity(i3, i4);
    chk("R6 irq without auto", i3, 1);
    chk("R5 sleep_rq kept", sleep_rq_o, 1);
    ticks(12);
    chk("R5 still asleep", sleep_ack_o, 1);
    wr(1'b0, 1'b0, 1'b0, 1'b1);
    ticks(11);
    chk("R4 sw wake normal", mode_o, 0);

    // R6 no irq when disabled
    wr(1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    activity(i3, i4);
    chk("R6 irq disabled", i3 | i4, 0);
    chk("R5 auto clear no irq", sleep_rq_o, 0);

    finish_run();
  end
endmodule